// File: doc/BRIEF.md
# Clock and Battery-Backed Memory Host Register Port

This block gives a host processor word-wide register access to two small stores: a 16-entry store of 4-bit clock nibbles and a 2048-entry store of bytes meant to be kept alive by a battery. The host selects a location by writing its address in inverted (one's-complement) form. It then reads or writes the data register repeatedly. Every data access steps the matching address counter to the next true location, so a whole block moves without the address being reloaded.

A status register holds warning and enable bits with fixed defaults. It also reports a battery-fail flag, sampled from a digital low-battery comparator just after power-up and readable only for a bounded number of clock-enable ticks. An interface-clear input shuts the host off from both stores and returns the address counters and the status register to their defaults.

Two state machines drive the block. The access controller has the states AC_CLEAR and AC_READY. It enters AC_CLEAR on reset or whenever clear is high, and moves to AC_READY on the first edge at which clear is low. The battery window has the states BW_SAMPLE, BW_OPEN and BW_CLOSED. BW_SAMPLE latches the comparator on the first edge after reset and moves to BW_OPEN. BW_OPEN moves to BW_CLOSED on the tick that completes the window. BW_CLOSED holds until reset.

Top module: `clkmem_host_regs`

## Requirements
- R1: After reset or interface clear, reading register 12 returns 0xFFFF and reading register 8 returns 0x000F. Both counters then point at true location 0.
- R2: After reset or interface clear, reading register 2 returns 0x0002 with the battery flag clear. Writes to register 2 set bit 0 (over-temperature warning), bit 1 (self-test enable), bits 4:2 (button interrupt enables) and bit 6 (UPS warning). Bit 5 cannot be written.
- R3: A write to register 8 loads the clock counter with bus_wdata[3:0], which is the inverted location. Reads and writes of register 9 reach the clock nibble at the inverse of the counter, carried in data bits 3:0.
- R4: A write to register 12 loads the 16-bit memory counter with bus_wdata and loads the clock counter with bus_wdata[3:0]. Reads and writes of register 13 reach the byte at the inverse of counter bits 10:0, carried in data bits 7:0.
- R5: Each read or write of register 9 steps only the clock counter, and each read or write of register 13 steps only the memory counter. A step advances the true location by one, which decrements the stored inverted value.
- R6: The memory counter wraps its true location modulo 2048 and leaves bits 15:11 unchanged. The clock counter wraps modulo 16.
- R7: While interface clear is high, no write reaches a store, no counter or status write takes effect, and bus_rdata reads 0.
- R8: An access in the first cycle after interface clear falls is ignored.
- R9: If the low-battery input is high on the first clock edge after reset, register 2 bit 5 reads 1.
- R10: Register 2 bit 5 reads 0 once WINDOW_TICKS tick pulses have been counted after reset.
- R11: Read data appears on bus_rdata after the clock edge that samples bus_rd. It holds until the next read or clear. Reading registers 2, 8 or 12 steps no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| ifc | input | 1 | Interface clear, active high |
| tick | input | 1 | Clock enable that times the battery window |
| batt_low | input | 1 | Low-battery comparator output |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Register number |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that each strobe lasts one cycle per access, that bus_rd and bus_wr are never high together, and that reset is applied before any check matters. The bench drives every access from a task that raises a single strobe for exactly one cycle, so these assumptions always hold. Random operations are mixed with directed ones: loads at the wrap boundaries, strobes under and just after interface clear, and a reset with the low-battery input high. Before the random phase, both stores are filled through the data registers, so every random read has a known expected value.

// File: rtl/clkmem_pkg.sv
package clkmem_pkg;

    typedef enum logic {
        AC_CLEAR = 1'b0,
        AC_READY = 1'b1
    } acc_state_t;

    typedef enum logic [1:0] {
        BW_SAMPLE = 2'd0,
        BW_OPEN   = 2'd1,
        BW_CLOSED = 2'd2
    } batt_state_t;

    localparam logic [3:0] REG_STATUS   = 4'd2;
    localparam logic [3:0] REG_RTC_ADDR = 4'd8;
    localparam logic [3:0] REG_RTC_DATA = 4'd9;
    localparam logic [3:0] REG_ADDR     = 4'd12;
    localparam logic [3:0] REG_NVM_DATA = 4'd13;

    localparam int STATUS_W = 7;
    localparam logic [STATUS_W-1:0] STATUS_DEFAULT = 7'b000_0010;
    localparam logic [STATUS_W-1:0] STATUS_WMASK   = 7'b101_1111;
    localparam int BATT_BIT = 5;

endpackage

// File: rtl/addr_stepper.sv
module addr_stepper #(
    parameter int W      = 16,
    parameter int STEP_W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] q
);

    logic [STEP_W-1:0] true_loc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else if (clr) begin
            q <= '1;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q[STEP_W-1:0] <= q[STEP_W-1:0] - 1'b1;
        end
    end

    assign true_loc = ~q[STEP_W-1:0];

    AST_STEP_NEXT_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !load) |=> true_loc == STEP_W'($past(true_loc) + 1'b1)); // R5

    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '1)); // R1

    generate
        if (W > STEP_W) begin : g_upper
            AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (step && !clr && !load) |=> $stable(q[W-1:STEP_W])); // R6
        end
    endgenerate

endmodule

// File: rtl/mem_store.sv
module mem_store #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/batt_window.sv
module batt_window
    import clkmem_pkg::*;
#(
    parameter int WINDOW_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic batt_low,
    output logic fail_flag
);

    localparam int CW = $clog2(WINDOW_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_TICKS - 1);

    batt_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BW_SAMPLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BW_SAMPLE: state_d = BW_OPEN;
            BW_OPEN:   if (tick && cnt_q == LAST) state_d = BW_CLOSED;
            BW_CLOSED: state_d = BW_CLOSED;
            default:   state_d = BW_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            unique case (state_q)
                BW_SAMPLE: begin
                    flag_q <= batt_low;
                    cnt_q  <= '0;
                end
                BW_OPEN: begin
                    if (tick) begin
                        if (cnt_q == LAST) begin
                            flag_q <= 1'b0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: flag_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        fail_flag = flag_q && (state_q == BW_OPEN);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R10

    AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == BW_OPEN && state_q == BW_OPEN) |-> fail_flag == $past(fail_flag)); // R9

    AST_CLOSED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BW_CLOSED) |=> (state_q == BW_CLOSED && !fail_flag)); // R10

endmodule

// File: rtl/clkmem_host_regs.sv
module clkmem_host_regs
    import clkmem_pkg::*;
#(
    parameter int NVM_DEPTH    = 2048,
    parameter int NVM_W        = 8,
    parameter int RTC_DEPTH    = 16,
    parameter int RTC_W        = 4,
    parameter int BUS_W        = 16,
    parameter int WINDOW_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ifc,
    input  logic             tick,
    input  logic             batt_low,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);

    localparam int NVM_AW = $clog2(NVM_DEPTH);
    localparam int RTC_AW = $clog2(RTC_DEPTH);

    acc_state_t acc_q, acc_d;
    logic open;
    logic rtc_load, rtc_step, rtc_we;
    logic nvm_load, nvm_step, nvm_we;
    logic stat_we, rd_ok;
    logic [RTC_AW-1:0] rtc_comp;
    logic [BUS_W-1:0]  nvm_comp;
    logic [RTC_AW-1:0] rtc_true;
    logic [NVM_AW-1:0] nvm_true;
    logic [RTC_W-1:0]  rtc_q;
    logic [NVM_W-1:0]  nvm_q;
    logic [STATUS_W-1:0] status_q, status_rd;
    logic batt_fail;

    // access controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= AC_CLEAR;
        else        acc_q <= acc_d;
    end

    always_comb begin
        acc_d = acc_q;
        unique case (acc_q)
            AC_CLEAR: acc_d = ifc ? AC_CLEAR : AC_READY;
            AC_READY: acc_d = ifc ? AC_CLEAR : AC_READY;
            default:  acc_d = AC_CLEAR;
        endcase
    end

    // access controller outputs
    always_comb begin
        open     = (acc_q == AC_READY) && !ifc;
        rtc_load = open && bus_wr && (bus_addr == REG_RTC_ADDR || bus_addr == REG_ADDR);
        nvm_load = open && bus_wr && (bus_addr == REG_ADDR);
        rtc_we   = open && bus_wr && (bus_addr == REG_RTC_DATA);
        nvm_we   = open && bus_wr && (bus_addr == REG_NVM_DATA);
        rtc_step = open && (bus_wr || bus_rd) && (bus_addr == REG_RTC_DATA);
        nvm_step = open && (bus_wr || bus_rd) && (bus_addr == REG_NVM_DATA);
        stat_we  = open && bus_wr && (bus_addr == REG_STATUS);
        rd_ok    = open && bus_rd && !bus_wr;
    end

    addr_stepper #(.W(RTC_AW), .STEP_W(RTC_AW)) u_rtc_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ifc),
        .load     (rtc_load),
        .load_val (bus_wdata[RTC_AW-1:0]),
        .step     (rtc_step),
        .q        (rtc_comp)
    );

    addr_stepper #(.W(BUS_W), .STEP_W(NVM_AW)) u_nvm_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ifc),
        .load     (nvm_load),
        .load_val (bus_wdata),
        .step     (nvm_step),
        .q        (nvm_comp)
    );

    assign rtc_true = ~rtc_comp;
    assign nvm_true = ~nvm_comp[NVM_AW-1:0];

    mem_store #(.DEPTH(RTC_DEPTH), .WIDTH(RTC_W)) u_rtc_mem (
        .clk   (clk),
        .we    (rtc_we),
        .addr  (rtc_true),
        .wdata (bus_wdata[RTC_W-1:0]),
        .rdata (rtc_q)
    );

    mem_store #(.DEPTH(NVM_DEPTH), .WIDTH(NVM_W)) u_nvm_mem (
        .clk   (clk),
        .we    (nvm_we),
        .addr  (nvm_true),
        .wdata (bus_wdata[NVM_W-1:0]),
        .rdata (nvm_q)
    );

    batt_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_batt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .batt_low  (batt_low),
        .fail_flag (batt_fail)
    );

    // status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_DEFAULT;
        end else if (ifc) begin
            status_q <= STATUS_DEFAULT;
        end else if (stat_we) begin
            status_q <= bus_wdata[STATUS_W-1:0] & STATUS_WMASK;
        end
    end

    always_comb begin
        status_rd = status_q;
        status_rd[BATT_BIT] = batt_fail;
    end

    // registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (ifc) begin
            bus_rdata <= '0;
        end else if (rd_ok) begin
            unique case (bus_addr)
                REG_STATUS:   bus_rdata <= BUS_W'(status_rd);
                REG_RTC_ADDR: bus_rdata <= BUS_W'(rtc_comp);
                REG_RTC_DATA: bus_rdata <= BUS_W'(rtc_q);
                REG_ADDR:     bus_rdata <= nvm_comp;
                REG_NVM_DATA: bus_rdata <= BUS_W'(nvm_q);
                default:      bus_rdata <= '0;
            endcase
        end
    end

    AST_IFC_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ifc) |-> (bus_rdata == '0)); // R7

    AST_IFC_STATUS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ifc |=> (status_q == STATUS_DEFAULT)); // R2

    AST_RECOVERY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ifc) |=> (nvm_comp == '1 && rtc_comp == '1)); // R8

    AST_NVM_READ_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (open && bus_rd && bus_addr == REG_NVM_DATA) |=> (nvm_comp != $past(nvm_comp))); // R5

    AST_ADDR_READ_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (open && bus_rd && bus_addr == REG_ADDR) |=> $stable(nvm_comp)); // R11

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R11

endmodule

// File: tb/clkmem_host_regs_tb.sv
module clkmem_host_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ifc = 1'b0;
    logic        tick = 1'b0;
    logic        batt_low = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_nvm [2048];
    logic [3:0]  m_rtc [16];
    logic [15:0] m_ncomp;
    logic [3:0]  m_rcomp;
    logic [6:0]  m_status;
    logic        m_batt;

    always #10 clk = ~clk;

    clkmem_host_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ifc       (ifc),
        .tick      (tick),
        .batt_low  (batt_low),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [15:0] exp_status();
        logic [6:0] s;
        s = m_status;
        s[5] = m_batt;
        return {9'd0, s};
    endfunction

    function automatic logic [15:0] step_comp(input logic [15:0] c);
        return {c[15:11], c[10:0] - 11'd1};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] q);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        q = bus_rdata;
    endtask

    task automatic model_defaults();
        m_ncomp = 16'hFFFF; m_rcomp = 4'hF; m_status = 7'h02;
    endtask

    task automatic do_reset(input logic blow);
        @(negedge clk);
        rst_n = 1'b0; batt_low = blow;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        batt_low = 1'b0;
        model_defaults();
        m_batt = blow;
    endtask

    task automatic w13(input logic [7:0] d);
        bus_write(4'd13, {8'd0, d});
        m_nvm[~m_ncomp[10:0]] = d; m_ncomp = step_comp(m_ncomp);
    endtask

    task automatic r13(input string req);
        logic [15:0] q;
        bus_read(4'd13, q);
        check(req, q, {8'd0, m_nvm[~m_ncomp[10:0]]});
        m_ncomp = step_comp(m_ncomp);
    endtask

    task automatic w9(input logic [3:0] d);
        bus_write(4'd9, {12'd0, d});
        m_rtc[~m_rcomp] = d; m_rcomp = m_rcomp - 4'd1;
    endtask

    task automatic r9(input string req);
        logic [15:0] q;
        bus_read(4'd9, q);
        check(req, q, {12'd0, m_rtc[~m_rcomp]});
        m_rcomp = m_rcomp - 4'd1;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] q;
        void'($urandom(32'd20240611));
        do_reset(1'b0);

        // R1 R2: reset values
        bus_read(4'd12, q); check("R1 nvm addr reset", q, 16'hFFFF);
        bus_read(4'd8, q);  check("R1 rtc addr reset", q, 16'h000F);
        bus_read(4'd2, q);  check("R2 status reset", q, 16'h0002);
        // R11: address reads do not step
        bus_read(4'd12, q); check("R11 addr read no step", q, 16'hFFFF);

        // R3 R4 R5: fill both stores by streaming from true 0
        for (int i = 0; i < 2048; i++) w13(8'(i * 37 + 5));
        check("R6 nvm wrapped after full fill", 16'(m_ncomp), 16'hFFFF);
        bus_read(4'd12, q); check("R6 nvm counter after 2048 steps", q, 16'hFFFF);
        for (int i = 0; i < 16; i++) w9(4'(i * 7 + 3));
        bus_read(4'd8, q); check("R6 rtc counter after 16 steps", q, 16'h000F);
        for (int i = 0; i < 8; i++) r13("R4 nvm stream read");
        for (int i = 0; i < 5; i++) r9("R3 rtc stream read");
        // R5: rtc access left nvm counter alone
        bus_read(4'd12, q); check("R5 nvm counter independent", q, m_ncomp);

        // R6: wrap at top with upper bits kept
        bus_write(4'd12, 16'hA800); m_ncomp = 16'hA800; m_rcomp = 4'h0;
        bus_read(4'd8, q); check("R4 rtc low nibble loaded", q, 16'h0000);
        r13("R6 nvm read at 0x7FF");
        bus_read(4'd12, q); check("R6 nvm wrap keeps upper", q, 16'hAFFF);
        r13("R6 nvm read at 0 after wrap");
        r9("R6 rtc read at 15");
        bus_read(4'd8, q); check("R6 rtc wrap", q, 16'h000F);

        // R3: register 8 alone moves only rtc
        bus_write(4'd8, 16'h0005); m_rcomp = 4'h5;
        r9("R3 rtc at true 10");
        bus_read(4'd12, q); check("R3 r8 leaves nvm counter", q, m_ncomp);

        // R2: status writes, bit 5 read-only
        bus_write(4'd2, 16'hFFFF); m_status = 7'h5F;
        bus_read(4'd2, q); check("R2 status write mask", q, exp_status());
        bus_write(4'd2, 16'h0040); m_status = 7'h40;
        bus_read(4'd2, q); check("R2 status ups only", q, exp_status());

        // R7: clear blocks everything
        @(negedge clk); ifc = 1'b1;
        @(negedge clk);
        bus_addr = 4'd13; bus_wdata = 16'h00EE; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        bus_addr = 4'd13; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        check("R7 rdata zero under clear", bus_rdata, 16'h0000);
        // R8: strobe in the first cycle after clear falls is ignored
        bus_addr = 4'd13; bus_wdata = 16'h00DD; bus_wr = 1'b1; ifc = 1'b0;
        @(negedge clk); bus_wr = 1'b0;
        model_defaults();
        bus_read(4'd12, q); check("R1 nvm addr after clear", q, 16'hFFFF);
        bus_read(4'd8, q);  check("R1 rtc addr after clear", q, 16'h000F);
        bus_read(4'd2, q);  check("R2 status after clear", q, 16'h0002);
        r13("R8 true 0 untouched by recovery write");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom_range(0, 6));
            unique case (op)
                0: begin
                    logic [15:0] d;
                    d = 16'($urandom);
                    bus_write(4'd12, d); m_ncomp = d; m_rcomp = d[3:0];
                end
                1: begin
                    logic [3:0] d;
                    d = 4'($urandom);
                    bus_write(4'd8, {12'd0, d}); m_rcomp = d;
                end
                2: w13(8'($urandom));
                3: r13("R4 random nvm read");
                4: w9(4'($urandom));
                5: r9("R3 random rtc read");
                default: begin
                    bus_read(4'd12, q); check("R5 random nvm counter", q, m_ncomp);
                    bus_read(4'd8, q);  check("R5 random rtc counter", q, {12'd0, m_rcomp});
                end
            endcase
        end

        // R9 R10: battery window
        do_reset(1'b1);
        bus_read(4'd2, q); check("R9 battery flag set", q, exp_status());
        check("R9 bit5 value", {15'd0, q[5]}, 16'd1);
        for (int t = 0; t < 3; t++) pulse_tick();
        bus_read(4'd2, q); check("R10 flag within window", {15'd0, q[5]}, 16'd1);
        pulse_tick(); m_batt = 1'b0;
        bus_read(4'd2, q); check("R10 flag after window", q, exp_status());
        r13("R4 store kept across reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule